// File: doc/BRIEF.md
# LPC I/O Burst Host

This block lets a processor run a short burst of byte-wide I/O cycles on an LPC-style bus through a small register window. Software sets a cycle count, a command word and a starting port address. For a write it also loads the data bytes into a write FIFO. It then sets the start bit. The engine runs the cycles one after another. Each cycle moves one byte, and the port either steps by one or stays fixed. Read bytes collect in a read FIFO. The outcome is shown as an idle bit and a separate finished-OK bit.

The bus side is abstracted into a per-cycle handshake. The engine raises a request for each cycle and holds it through a fixed header phase of `HDR_CLKS` clocks. It then waits in a sync phase until the target pulses ready for one clock. The target may stretch the sync phase by up to `MAX_WAIT` extra clocks. If it stretches past that limit, the engine aborts the burst and discards the cycles that remain. Completion, whether successful or aborted, also sets a write-1-to-clear completion flag.

Top module: `lpc_burst_host`

## Requirements
- R1: After reset the status register (offset 0x04) reads 1, meaning bit 0 (idle) is set and bit 1 (finished OK) is clear. The completion flag (offset 0x08, bit 1) reads 0. A read of the read-data register (offset 0x28) with an empty read FIFO returns 0.
- R2: When the engine is idle, a write to offset 0x00 with bit 0 set launches a burst using the programmed length (offset 0x10, bits 7:0). From the next clock the status idle bit reads 0. `lpc_req_o` is only asserted while the engine is busy.
- R3: A start with a length of 0 or greater than `MAX_LEN` (16) is ignored. The status does not change and no bus cycle runs.
- R4: Command bit 0 selects the direction: 1 is write, 0 is read. Each bus cycle moves exactly one byte. When command bit 3 is clear, the port address starts at the value of the address register (offset 0x20) and increases by one after each cycle.
- R5: When command bit 3 is set, every cycle of the burst uses the same port address.
- R6: Writes to offset 0x24 (bits 7:0) queue bytes. A write burst sends them in the order they were queued. Bytes still queued when a burst ends are discarded.
- R7: A read burst stores each received byte in the read FIFO. Reads of offset 0x28 return the bytes in arrival order. Launching a new burst empties the read FIFO.
- R8: A cycle whose ready arrives at most `MAX_WAIT` (256) clocks after the sync phase begins completes normally. If ready has not arrived by then, the burst aborts: no further cycles run, the engine returns to idle and the finished-OK bit stays clear.
- R9: If a write burst needs a byte while the write FIFO is empty, the burst aborts at that cycle. The cycles already done stand, and the engine ends idle with finished-OK clear.
- R10: A start written while the engine is busy is ignored. The running burst keeps its length, direction and address.
- R11: Completion bit 1 at offset 0x08 is set when any burst ends, whether it succeeded or aborted. Writing 1 to that bit clears it, and writing 0 leaves it unchanged.
- R12: The finished-OK bit (status bit 1) is set only when all programmed cycles complete. After an abort the status reads idle with bit 1 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (pops the read FIFO at offset 0x28) |
| reg_addr_i | input | 6 | Register byte offset |
| reg_wdata_i | input | REG_W (16) | Register write data |
| reg_rdata_o | output | REG_W (16) | Register read data, combinational from the offset |
| lpc_req_o | output | 1 | Bus cycle in progress (header and sync phases) |
| lpc_write_o | output | 1 | Direction of the current cycle |
| lpc_addr_o | output | ADDR_W (16) | Port address of the current cycle |
| lpc_wdata_o | output | 8 | Byte driven on a write cycle |
| lpc_ready_i | input | 1 | One-clock ready pulse from the target during sync |
| lpc_rdata_i | input | 8 | Byte returned by the target, valid with ready |

## Verification
Some properties are checked by assertions on every clock: FIFO occupancy stays bounded, the sync wait counter never passes its limit, ready and abort never coincide, and the bus address stays stable within a cycle. Assertions also check that the request appears only while busy, that finished-OK implies idle, that the address steps after each cycle or holds in fixed-port mode, and that every completion raises the flag. Other behaviour needs the bench scenarios. These cover the exact byte order and address pattern across every burst length, the boundary between a 256-clock and a 257-clock stall, ignored starts (busy, or with a bad length), short write FIFOs, discarding of leftover write bytes, and flushing of the read FIFO.

// File: rtl/lpc_burst_pkg.sv
package lpc_burst_pkg;
  localparam logic [5:0] OFS_GO   = 6'h00;
  localparam logic [5:0] OFS_STAT = 6'h04;
  localparam logic [5:0] OFS_IRQ  = 6'h08;
  localparam logic [5:0] OFS_LEN  = 6'h10;
  localparam logic [5:0] OFS_CMD  = 6'h14;
  localparam logic [5:0] OFS_PORT = 6'h20;
  localparam logic [5:0] OFS_WDAT = 6'h24;
  localparam logic [5:0] OFS_RDAT = 6'h28;

  localparam int CMD_DIR_BIT = 0;
  localparam int CMD_FIX_BIT = 3;
  localparam int LEN_FIELD_W = 8;

  typedef enum logic [1:0] {CT_IDLE, CT_ISSUE, CT_WAIT} ctl_st_e;
  typedef enum logic [1:0] {SQ_IDLE, SQ_HEAD, SQ_SYNC} seq_st_e;
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;
  logic             do_push, do_pop;

  assign empty_o = (cnt == '0);
  assign full_o  = (cnt == CNT_W'(DEPTH));
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;
  assign data_o  = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (flush_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      if (do_push && !do_pop)      cnt <= cnt + 1'b1;
      else if (do_pop && !do_push) cnt <= cnt - 1'b1;
    end
  end

  a_r7_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CNT_W'(DEPTH));
  a_r7_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
endmodule

// File: rtl/lpc_cycle_seq.sv
module lpc_cycle_seq
  import lpc_burst_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int HDR_CLKS = 13,
  parameter int MAX_WAIT = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic              done_o,
  output logic              err_o,
  output logic [7:0]        rdata_o,
  output logic              lpc_req_o,
  output logic              lpc_write_o,
  output logic [ADDR_W-1:0] lpc_addr_o,
  output logic [7:0]        lpc_wdata_o,
  input  logic              lpc_ready_i,
  input  logic [7:0]        lpc_rdata_i
);
  localparam int HDR_W  = $clog2(HDR_CLKS + 1);
  localparam int WAIT_W = $clog2(MAX_WAIT + 1);

  seq_st_e            st;
  logic [HDR_W-1:0]   hdr_cnt;
  logic [WAIT_W-1:0]  wait_cnt;
  logic               wr_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [7:0]         wd_q;
  logic               at_limit;

  assign at_limit    = (wait_cnt == WAIT_W'(MAX_WAIT));
  assign done_o      = (st == SQ_SYNC) && lpc_ready_i;
  assign err_o       = (st == SQ_SYNC) && !lpc_ready_i && at_limit;
  assign rdata_o     = lpc_rdata_i;
  assign lpc_req_o   = (st != SQ_IDLE);
  assign lpc_write_o = wr_q;
  assign lpc_addr_o  = addr_q;
  assign lpc_wdata_o = wd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st       <= SQ_IDLE;
      hdr_cnt  <= '0;
      wait_cnt <= '0;
      wr_q     <= 1'b0;
      addr_q   <= '0;
      wd_q     <= '0;
    end else begin
      unique case (st)
        SQ_IDLE: if (start_i) begin
          st      <= SQ_HEAD;
          hdr_cnt <= '0;
          wr_q    <= write_i;
          addr_q  <= addr_i;
          wd_q    <= wdata_i;
        end
        SQ_HEAD: begin
          if (hdr_cnt == HDR_W'(HDR_CLKS - 1)) begin
            st       <= SQ_SYNC;
            wait_cnt <= '0;
          end else begin
            hdr_cnt <= hdr_cnt + 1'b1;
          end
        end
        SQ_SYNC: begin
          if (lpc_ready_i || at_limit) st <= SQ_IDLE;
          else wait_cnt <= wait_cnt + 1'b1;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  a_r8_wait_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == SQ_SYNC) |-> (wait_cnt <= WAIT_W'(MAX_WAIT)));
  a_r8_done_err_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));
  a_r4_addr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lpc_req_o && $past(lpc_req_o)) |-> $stable(lpc_addr_o));
  a_r8_end_drops_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || err_o) |=> !lpc_req_o);
endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import lpc_burst_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int MAX_LEN = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   go_i,
  input  logic [LEN_FIELD_W-1:0] len_i,
  input  logic                   dir_wr_i,
  input  logic                   fixed_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic                   wf_empty_i,
  input  logic [7:0]             wf_data_i,
  output logic                   wf_pop_o,
  output logic                   wf_flush_o,
  output logic                   rf_push_o,
  output logic [7:0]             rf_data_o,
  output logic                   rf_flush_o,
  output logic                   sq_start_o,
  output logic                   sq_write_o,
  output logic [ADDR_W-1:0]      sq_addr_o,
  output logic [7:0]             sq_wdata_o,
  input  logic                   sq_done_i,
  input  logic                   sq_err_i,
  input  logic [7:0]             sq_rdata_i,
  output logic                   idle_o,
  output logic                   ok_o,
  output logic                   fin_o
);
  localparam int RM_W = $clog2(MAX_LEN + 1);

  ctl_st_e           st;
  logic [RM_W-1:0]   remain;
  logic [ADDR_W-1:0] cur_addr;
  logic              wr_q, fix_q, idle_q, ok_q;
  logic              launch, starve, last_done;

  assign launch    = go_i && (st == CT_IDLE) && (len_i != '0) &&
                     (len_i <= LEN_FIELD_W'(MAX_LEN));
  assign starve    = (st == CT_ISSUE) && wr_q && wf_empty_i;
  assign last_done = (st == CT_WAIT) && sq_done_i && (remain == RM_W'(1));

  assign sq_start_o = (st == CT_ISSUE) && !starve;
  assign sq_write_o = wr_q;
  assign sq_addr_o  = cur_addr;
  assign sq_wdata_o = wf_data_i;
  assign wf_pop_o   = sq_start_o && wr_q;
  assign rf_push_o  = (st == CT_WAIT) && sq_done_i && !wr_q;
  assign rf_data_o  = sq_rdata_i;
  assign rf_flush_o = launch;
  assign fin_o      = starve || last_done || ((st == CT_WAIT) && sq_err_i);
  assign wf_flush_o = fin_o;
  assign idle_o     = idle_q;
  assign ok_o       = ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st       <= CT_IDLE;
      remain   <= '0;
      cur_addr <= '0;
      wr_q     <= 1'b0;
      fix_q    <= 1'b0;
      idle_q   <= 1'b1;
      ok_q     <= 1'b0;
    end else begin
      unique case (st)
        CT_IDLE: if (launch) begin
          st       <= CT_ISSUE;
          remain   <= RM_W'(len_i);
          cur_addr <= addr_i;
          wr_q     <= dir_wr_i;
          fix_q    <= fixed_i;
          idle_q   <= 1'b0;
          ok_q     <= 1'b0;
        end
        CT_ISSUE: begin
          if (starve) begin
            st     <= CT_IDLE;
            idle_q <= 1'b1;
          end else begin
            st <= CT_WAIT;
          end
        end
        CT_WAIT: begin
          if (sq_err_i) begin
            st     <= CT_IDLE;
            idle_q <= 1'b1;
          end else if (sq_done_i) begin
            if (remain == RM_W'(1)) begin
              st     <= CT_IDLE;
              idle_q <= 1'b1;
              ok_q   <= 1'b1;
            end else begin
              st     <= CT_ISSUE;
              remain <= remain - 1'b1;
              if (!fix_q) cur_addr <= cur_addr + 1'b1;
            end
          end
        end
        default: st <= CT_IDLE;
      endcase
    end
  end

  a_r12_ok_implies_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_q |-> idle_q);
  a_r3_remain_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    remain <= RM_W'(MAX_LEN));
  a_r4_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st == CT_WAIT) && sq_done_i && !sq_err_i && !fix_q && (remain != RM_W'(1)))
    |=> (cur_addr == ADDR_W'($past(cur_addr) + 1'b1)));
  a_r5_fixed_port: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle_q && $past(!idle_q) && fix_q) |-> $stable(cur_addr));
  a_r10_busy_no_relaunch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle_q && go_i) |=> !rf_flush_o || idle_q || $past(idle_q));
endmodule

// File: rtl/lpc_burst_host.sv
module lpc_burst_host
  import lpc_burst_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int MAX_LEN    = 16,
  parameter int FIFO_DEPTH = 16,
  parameter int HDR_CLKS   = 13,
  parameter int MAX_WAIT   = 256,
  localparam int REG_W     = (ADDR_W > LEN_FIELD_W) ? ADDR_W : LEN_FIELD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [5:0]        reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              lpc_req_o,
  output logic              lpc_write_o,
  output logic [ADDR_W-1:0] lpc_addr_o,
  output logic [7:0]        lpc_wdata_o,
  input  logic              lpc_ready_i,
  input  logic [7:0]        lpc_rdata_i
);
  logic [LEN_FIELD_W-1:0] len_q;
  logic [3:0]             cmd_q;
  logic [ADDR_W-1:0]      port_q;
  logic                   irq_q;

  logic go, wpush, rpop;
  logic wf_empty, wf_full, wf_pop, wf_flush;
  logic rf_empty, rf_full, rf_push, rf_flush;
  logic [7:0] wf_data, rf_wdata, rf_data;
  logic sq_start, sq_write, sq_done, sq_err;
  logic [ADDR_W-1:0] sq_addr;
  logic [7:0] sq_wdata, sq_rdata;
  logic idle, ok, fin;

  assign go    = reg_we_i && (reg_addr_i == OFS_GO) && reg_wdata_i[0];
  assign wpush = reg_we_i && (reg_addr_i == OFS_WDAT);
  assign rpop  = reg_re_i && (reg_addr_i == OFS_RDAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q  <= '0;
      cmd_q  <= '0;
      port_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (reg_we_i) begin
        unique case (reg_addr_i)
          OFS_LEN:  len_q  <= reg_wdata_i[LEN_FIELD_W-1:0];
          OFS_CMD:  cmd_q  <= reg_wdata_i[3:0];
          OFS_PORT: port_q <= reg_wdata_i[ADDR_W-1:0];
          default: ;
        endcase
      end
      if (fin) irq_q <= 1'b1;
      else if (reg_we_i && (reg_addr_i == OFS_IRQ) && reg_wdata_i[1]) irq_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      OFS_STAT: reg_rdata_o = REG_W'({ok, idle});
      OFS_IRQ:  reg_rdata_o = REG_W'({irq_q, 1'b0});
      OFS_LEN:  reg_rdata_o = REG_W'(len_q);
      OFS_CMD:  reg_rdata_o = REG_W'(cmd_q);
      OFS_PORT: reg_rdata_o = REG_W'(port_q);
      OFS_RDAT: reg_rdata_o = rf_empty ? '0 : REG_W'(rf_data);
      default:  reg_rdata_o = '0;
    endcase
  end

  byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_wfifo (
    .clk_i, .rst_ni,
    .flush_i(wf_flush), .push_i(wpush), .data_i(reg_wdata_i[7:0]),
    .pop_i(wf_pop), .data_o(wf_data), .empty_o(wf_empty), .full_o(wf_full)
  );

  byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_rfifo (
    .clk_i, .rst_ni,
    .flush_i(rf_flush), .push_i(rf_push), .data_i(rf_wdata),
    .pop_i(rpop), .data_o(rf_data), .empty_o(rf_empty), .full_o(rf_full)
  );

  burst_ctrl #(.ADDR_W(ADDR_W), .MAX_LEN(MAX_LEN)) u_ctrl (
    .clk_i, .rst_ni,
    .go_i(go), .len_i(len_q), .dir_wr_i(cmd_q[CMD_DIR_BIT]),
    .fixed_i(cmd_q[CMD_FIX_BIT]), .addr_i(port_q),
    .wf_empty_i(wf_empty), .wf_data_i(wf_data), .wf_pop_o(wf_pop),
    .wf_flush_o(wf_flush), .rf_push_o(rf_push), .rf_data_o(rf_wdata),
    .rf_flush_o(rf_flush), .sq_start_o(sq_start), .sq_write_o(sq_write),
    .sq_addr_o(sq_addr), .sq_wdata_o(sq_wdata), .sq_done_i(sq_done),
    .sq_err_i(sq_err), .sq_rdata_i(sq_rdata),
    .idle_o(idle), .ok_o(ok), .fin_o(fin)
  );

  lpc_cycle_seq #(.ADDR_W(ADDR_W), .HDR_CLKS(HDR_CLKS), .MAX_WAIT(MAX_WAIT)) u_seq (
    .clk_i, .rst_ni,
    .start_i(sq_start), .write_i(sq_write), .addr_i(sq_addr), .wdata_i(sq_wdata),
    .done_o(sq_done), .err_o(sq_err), .rdata_o(sq_rdata),
    .lpc_req_o, .lpc_write_o, .lpc_addr_o, .lpc_wdata_o,
    .lpc_ready_i, .lpc_rdata_i
  );

  a_r2_req_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lpc_req_o |-> !idle);
  a_r11_flag_on_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin |=> irq_q);
  a_r7_no_rf_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_push |-> !rf_full);
  a_r6_pop_has_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wf_pop |-> !wf_empty);
endmodule

// File: tb/sim_lpc_burst_host.sv
module sim_lpc_burst_host;
  localparam int HDR = 13;
  localparam logic [5:0] A_GO = 6'h00, A_ST = 6'h04, A_IRQ = 6'h08, A_LEN = 6'h10,
                         A_CMD = 6'h14, A_PORT = 6'h20, A_WD = 6'h24, A_RD = 6'h28;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        lpc_req, lpc_write, lpc_ready;
  logic [15:0] lpc_addr;
  logic [7:0]  lpc_wdata, lpc_rdata;

  int n_chk = 0, n_fail = 0;
  int tcount = 0, rcnt = 0, stall_n = 0;
  bit done_flag = 0;
  logic [15:0] log_a [256];
  logic [7:0]  log_d [256];
  logic        log_w [256];

  always #2 clk = ~clk;

  lpc_burst_host u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_re_i(reg_re),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .lpc_req_o(lpc_req), .lpc_write_o(lpc_write), .lpc_addr_o(lpc_addr),
    .lpc_wdata_o(lpc_wdata), .lpc_ready_i(lpc_ready), .lpc_rdata_i(lpc_rdata)
  );

  // target model: ready after HDR header clocks plus stall_n sync clocks
  assign lpc_ready = lpc_req && (rcnt == HDR + stall_n);
  assign lpc_rdata = lpc_addr[7:0] ^ tcount[7:0];

  always @(posedge clk) begin
    if (!lpc_req) rcnt <= 0;
    else rcnt <= rcnt + 1;
    if (lpc_req && lpc_ready) begin
      log_a[tcount[7:0]] <= lpc_addr;
      log_d[tcount[7:0]] <= lpc_wdata;
      log_w[tcount[7:0]] <= lpc_write;
      tcount <= tcount + 1;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, int d);
    @(negedge clk);
    reg_addr = a; reg_wdata = 16'(d); reg_we = 1'b1;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output int d);
    @(negedge clk);
    reg_addr = a; reg_re = 1'b1;
    #1 d = int'(reg_rdata);
    @(posedge clk); #1;
    reg_re = 1'b0;
  endtask

  task automatic wait_idle(string req);
    int s = 0;
    for (int i = 0; i < 3000; i++) begin
      rd(A_ST, s);
      if (s[0]) return;
    end
    chk(req, s, 1);
  endtask

  task automatic run_read(string req, int len, bit fixed, int port);
    int base, s, d;
    wr(A_LEN, len); wr(A_CMD, fixed ? 8 : 0); wr(A_PORT, port);
    base = tcount;
    wr(A_GO, 1);
    rd(A_ST, s); chk("R2 busy after start", s & 1, 0);
    wait_idle(req);
    rd(A_ST, s); chk({req, " status ok"}, s, 3);
    chk({req, " cycle count"}, tcount - base, len);
    for (int k = 0; k < len; k++) begin
      int pa = fixed ? port : ((port + k) & 16'hffff);
      rd(A_RD, d);
      chk({req, " read byte"}, d, (pa ^ (base + k)) & 8'hff);
      chk({req, " read addr"}, int'(log_a[(base + k) & 255]), pa);
    end
    rd(A_RD, d); chk("R7 drained fifo reads 0", d, 0);
  endtask

  task automatic run_write(string req, int len, bit fixed, int port, int seed);
    int base, s;
    for (int k = 0; k < len; k++) wr(A_WD, (seed + k * 7) & 8'hff);
    wr(A_LEN, len); wr(A_CMD, fixed ? 9 : 1); wr(A_PORT, port);
    base = tcount;
    wr(A_GO, 1);
    wait_idle(req);
    rd(A_ST, s); chk({req, " status ok"}, s, 3);
    chk({req, " cycle count"}, tcount - base, len);
    for (int k = 0; k < len; k++) begin
      int i = (base + k) & 255;
      chk({req, " write dir"}, int'(log_w[i]), 1);
      chk({req, " write addr"}, int'(log_a[i]), fixed ? port : ((port + k) & 16'hffff));
      chk("R6 write byte order", int'(log_d[i]), (seed + k * 7) & 8'hff);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int s, d, base;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(A_ST, s);  chk("R1 status after reset", s, 1);
    rd(A_IRQ, s); chk("R1 flag after reset", s, 0);
    rd(A_RD, d);  chk("R1 empty read data", d, 0);
    chk("R1 no bus request", int'(lpc_req), 0);

    // R4 incrementing write, R5 fixed-port write
    run_write("R4 write inc", 4, 1'b0, 16'h03f8, 8'h11);
    // R11 completion flag
    rd(A_IRQ, s); chk("R11 flag set", s, 2);
    wr(A_IRQ, 0); rd(A_IRQ, s); chk("R11 write 0 keeps flag", s, 2);
    wr(A_IRQ, 2); rd(A_IRQ, s); chk("R11 write 1 clears flag", s, 0);
    run_write("R5 write fixed", 16, 1'b1, 16'h0060, 8'h80);

    // R4/R5 reads, address wrap
    run_read("R4 read inc", 16, 1'b0, 16'h0100);
    run_read("R5 read fixed", 5, 1'b1, 16'h02e8);
    run_read("R4 read wrap", 3, 1'b0, 16'hfffe);

    // near-exhaustive sweep over lengths and modes
    for (int L = 1; L <= 16; L++) begin
      run_read("R4 sweep read", L, L[0], 16'h0200 + L * 16);
      run_write("R6 sweep write", L, ~L[0], 16'h0400 + L * 16, L * 3);
    end

    // R3 bad lengths ignored
    rd(A_ST, s);
    base = tcount;
    wr(A_CMD, 0); wr(A_LEN, 0); wr(A_GO, 1);
    rd(A_ST, d); chk("R3 length 0 status unchanged", d, s);
    wr(A_LEN, 17); wr(A_GO, 1);
    repeat (40) @(posedge clk);
    rd(A_ST, d); chk("R3 length 17 status unchanged", d, s);
    chk("R3 no cycles", tcount - base, 0);

    // R10 start while busy ignored
    wr(A_LEN, 8); wr(A_CMD, 0); wr(A_PORT, 16'h0040);
    base = tcount;
    wr(A_GO, 1);
    wr(A_LEN, 2); wr(A_CMD, 1); wr(A_PORT, 0); wr(A_GO, 1);
    wait_idle("R10");
    rd(A_ST, s); chk("R10 status", s, 3);
    chk("R10 cycle count kept", tcount - base, 8);
    for (int k = 0; k < 8; k++) begin
      rd(A_RD, d); chk("R10 read byte", d, ((16'h40 + k) ^ (base + k)) & 8'hff);
    end

    // R7 read fifo flushed by new burst
    run_read("R7 prep", 1, 1'b0, 16'h0010);
    wr(A_LEN, 2); wr(A_CMD, 0); wr(A_PORT, 16'h0010); wr(A_GO, 1);
    wait_idle("R7");
    wr(A_LEN, 1); wr(A_PORT, 16'h0020);
    base = tcount;
    wr(A_GO, 1);
    wait_idle("R7");
    rd(A_RD, d); chk("R7 only new byte", d, (16'h20 ^ base) & 8'hff);
    rd(A_RD, d); chk("R7 old bytes flushed", d, 0);

    // R8 stall boundary
    stall_n = 256;
    run_read("R8 stall 256 ok", 1, 1'b0, 16'h0080);
    stall_n = 257;
    wr(A_IRQ, 2);
    wr(A_LEN, 3); wr(A_CMD, 0); wr(A_PORT, 16'h0090);
    base = tcount;
    wr(A_GO, 1);
    wait_idle("R8");
    rd(A_ST, s); chk("R12 abort status", s, 1);
    chk("R8 remaining cycles dropped", tcount - base, 0);
    repeat (40) @(posedge clk);
    chk("R8 no further request", int'(lpc_req), 0);
    rd(A_RD, d); chk("R8 no read bytes", d, 0);
    rd(A_IRQ, d); chk("R11 flag set on abort", d, 2);
    stall_n = 0;

    // R9 short write fifo
    for (int k = 0; k < 2; k++) wr(A_WD, 8'hc0 + k);
    wr(A_LEN, 3); wr(A_CMD, 1); wr(A_PORT, 16'h0300);
    base = tcount;
    wr(A_GO, 1);
    wait_idle("R9");
    rd(A_ST, s); chk("R9 abort status", s, 1);
    chk("R9 cycles before starve", tcount - base, 2);
    chk("R9 second byte", int'(log_d[(base + 1) & 255]), 8'hc1);

    // R6 leftover bytes discarded
    for (int k = 0; k < 5; k++) wr(A_WD, 8'h50 + k);
    wr(A_LEN, 2); wr(A_GO, 1);
    wait_idle("R6");
    rd(A_ST, s); chk("R6 partial use ok", s, 3);
    wr(A_LEN, 1);
    base = tcount;
    wr(A_GO, 1);
    wait_idle("R6");
    rd(A_ST, s); chk("R6 leftovers discarded", s, 1);
    chk("R6 no cycle from leftovers", tcount - base, 0);

    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule